// File: doc/BRIEF.md
# Multi-Mode Watchdog and Bus-Monitor Timer

This block is a single down-counter, `CNT_W` bits wide, that works in one of three modes. As a general-purpose timer it counts down and then reloads, over and over. As a watchdog it counts only while the core is awake, and software must refresh it with a two-word key sequence. As a bus monitor it is armed by the start of each bus cycle and stopped by that cycle's ready strobe, so it expires only when a cycle hangs for longer than the reload interval.

Every expiry produces a timeout pulse of exactly `PULSE_LEN` clocks, eight by default. An inverted copy of the pulse is also provided as an active-low interrupt request. The timeout output can drive a reset or a nonmaskable interrupt input elsewhere on the chip. Software controls the block through a small write-only port that selects one of three registers: control, reload and service.

Top module: `wdog_busmon_timer`

## Requirements
- R1: After reset the block is enabled in general-purpose mode and the reload value is `RST_RELOAD` (default 4,194,304). `tmo_pulse` is low and `tmo_irq_n` is high while reset is held. The first pulse rises on the `RST_RELOAD`-th rising clock edge after reset is released.
- R2: In general-purpose mode the counter decrements once per clock. A pulse starts on the edge where the count goes from 1 to 0, and the next edge reloads the counter from the reload register. Later pulses therefore start every reload+1 clocks. `core_idle` has no effect in this mode.
- R3: Each expiry drives `tmo_pulse` high for exactly `PULSE_LEN` (8) consecutive clocks.
- R4: `tmo_irq_n` is always the logical inverse of `tmo_pulse`.
- R5: If the counter expires while a pulse is still high, the pulse restarts from its first clock. The output stays high until `PULSE_LEN` clocks after the last expiry.
- R6: In watchdog mode the counter holds its value on every clock where `core_idle` is high.
- R7: In watchdog mode, two consecutive port writes to the service register (`cfg_sel`=2), first 0xAAAA and then 0x5555 in bits [15:0], reload the counter. The following are all ignored: any other value, any other write placed between the two, and the same sequence written in another mode.
- R8: A control write that selects bus-monitor mode loads the counter but leaves it stopped. A low level on `bus_start_n` reloads the counter and starts it. A pulse then starts reload clocks later, unless another start arrives first. After expiry the counter stays stopped at zero until the next start.
- R9: In bus-monitor mode a low level on `bus_ready_n` stops the counter, so no pulse follows. When start and ready are low on the same clock, the start wins.
- R10: In bus-monitor mode `core_idle` has no effect.
- R11: Port writes use the following encodings:
  - `cfg_sel`=0 (control): bits [1:0] select the mode (0 general-purpose, 1 watchdog, 2 bus monitor, 3 general-purpose) and bit 2 is the enable. A control write reloads the counter.
  - `cfg_sel`=1 (reload): bits [CNT_W-1:0] are stored as the new reload value. The stored value takes effect at the next reload and does not disturb the count in progress.
- R12: While the block is disabled the counter does not count and no pulse is produced. `tmo_pulse` is low from the edge that takes the disabling control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start_n | input | 1 | Bus-cycle start strobe, active low |
| bus_ready_n | input | 1 | Bus-cycle ready strobe, active low |
| core_idle | input | 1 | High while the core clocks are stopped |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 reload, 2 service |
| cfg_wdata | input | DATA_W | Register write data |
| tmo_pulse | output | 1 | Timeout pulse, PULSE_LEN clocks high |
| tmo_irq_n | output | 1 | Inverted timeout, active-low interrupt request |

## Verification
A wrong count, a missed reload or a bad mode decode shows up only as a timeout edge that arrives at the wrong clock. A fault can therefore stay hidden for a whole reload interval, or longer than that when it is an extra hold or a missing start. For this reason every scenario measures the exact edge at which the pulse rises, relative to the write or strobe that set it up, and also measures the pulse's high width. Faults in the pulse sequencer appear within eight clocks as a wrong width or as a gap when one pulse overlaps the next.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      MODE_GPT  = 2'd0,
      MODE_WDG  = 2'd1,
      MODE_BMON = 2'd2
   } wdt_mode_e;

   localparam int          SEL_W       = 2;
   localparam logic [1:0]  SEL_CTRL    = 2'd0;
   localparam logic [1:0]  SEL_RELOAD  = 2'd1;
   localparam logic [1:0]  SEL_SERVICE = 2'd2;
   localparam int          CTRL_EN_BIT = 2;

   // Code 3 is not a mode of its own and falls back to general-purpose.
   function automatic wdt_mode_e decode_mode(input logic [1:0] field);
      case (field)
         2'd1:    return MODE_WDG;
         2'd2:    return MODE_BMON;
         default: return MODE_GPT;
      endcase
   endfunction

endpackage

// File: rtl/wdt_svc_unlock.sv
module wdt_svc_unlock #(
   parameter int              DATA_W = 32,
   parameter int              KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY_A = 16'hAAAA,
   parameter logic [KEY_W-1:0] KEY_B = 16'h5555
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_is_svc,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              allow,
   output logic              kick_o
);

   logic             armed_q;
   logic [KEY_W-1:0] key;
   logic             is_first;
   logic             is_second;

   assign key       = wr_data[KEY_W-1:0];
   assign is_first  = wr_is_svc && (key == KEY_A) && allow;
   assign is_second = wr_is_svc && (key == KEY_B) && allow;

   // Every port write either re-arms or disarms, so the key words
   // must be back to back.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_en) begin
         armed_q <= is_first;
      end
   end

   assign kick_o = wr_en && armed_q && is_second;

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
   import wdt_pkg::*;
#(
   parameter int               CNT_W   = 32,
   parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(32'h0040_0000)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  wdt_mode_e        mode,
   input  logic             idle,
   input  logic             start_n,
   input  logic             ready_n,
   input  logic             restart,
   input  logic             restart_run,
   input  logic             kick,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             run_q, run_d;
   logic             step, load;

   always_comb begin
      step  = 1'b0;
      load  = 1'b0;
      run_d = run_q;
      if (restart) begin
         load  = 1'b1;
         run_d = restart_run;
      end else if (enable) begin
         case (mode)
            MODE_BMON: begin
               if (!start_n) begin
                  load  = 1'b1;
                  run_d = 1'b1;
               end else if (!ready_n) begin
                  run_d = 1'b0;
               end else if (run_q) begin
                  if (cnt_q == ZERO) begin
                     run_d = 1'b0;
                  end else begin
                     step = 1'b1;
                     if (cnt_q == ONE) run_d = 1'b0;
                  end
               end
            end
            MODE_WDG: begin
               if (kick)       load = 1'b1;
               else if (!idle) step = 1'b1;
            end
            default: step = 1'b1;
         endcase
      end
   end

   always_comb begin
      if (load)                          cnt_d = reload_val;
      else if (step && cnt_q == ZERO)    cnt_d = reload_val;
      else if (step)                     cnt_d = cnt_q - ONE;
      else                               cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
         run_q <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         run_q <= run_d;
      end
   end

   assign cnt_o    = cnt_q;
   assign expire_o = step && (cnt_q == ONE);

endmodule

// File: rtl/wdt_pulse_stretch.sv
module wdt_pulse_stretch #(
   parameter int PULSE_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clear,
   output logic pulse_o
);

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pulse_q <= 1'b0;
            else if (clear) pulse_q <= 1'b0;
            else            pulse_q <= fire;
         end
         assign pulse_o = pulse_q;
      end else begin : g_stretch
         localparam int          PW   = $clog2(PULSE_LEN);
         localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);
         localparam logic [PW-1:0] STEP = PW'(1);
         logic [PW-1:0] idx_q;
         logic          active_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q    <= '0;
               active_q <= 1'b0;
            end else if (clear) begin
               idx_q    <= '0;
               active_q <= 1'b0;
            end else if (fire) begin
               idx_q    <= '0;
               active_q <= 1'b1;
            end else if (active_q) begin
               if (idx_q == LAST) active_q <= 1'b0;
               else               idx_q    <= idx_q + STEP;
            end
         end
         assign pulse_o = active_q;
      end
   endgenerate

endmodule

// File: rtl/wdog_busmon_timer.sv
module wdog_busmon_timer
   import wdt_pkg::*;
#(
   parameter int               CNT_W      = 32,
   parameter int               DATA_W     = 32,
   parameter int               KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_A      = 16'hAAAA,
   parameter logic [KEY_W-1:0] KEY_B      = 16'h5555,
   parameter int               PULSE_LEN  = 8,
   parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(32'h0040_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start_n,
   input  logic              bus_ready_n,
   input  logic              core_idle,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              tmo_pulse,
   output logic              tmo_irq_n
);

   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must be at least 8 and no wider than DATA_W");
      end
      if (KEY_W > DATA_W || KEY_A == KEY_B) begin : g_bad_key
         $error("service keys must fit DATA_W and differ");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least 1");
      end
      if (RST_RELOAD == '0) begin : g_bad_reload
         $error("RST_RELOAD must be non-zero");
      end
   endgenerate

   wdt_mode_e        mode_q;
   logic             en_q;
   logic [CNT_W-1:0] reload_q;

   logic             wr_ctrl, wr_reload, wr_svc;
   logic             new_en;
   wdt_mode_e        new_mode;
   logic             restart, restart_run;
   logic             svc_allow, kick;
   logic             expire, pulse_clr, pulse;
   logic [CNT_W-1:0] cnt;

   assign wr_ctrl     = cfg_we && (cfg_sel == SEL_CTRL);
   assign wr_reload   = cfg_we && (cfg_sel == SEL_RELOAD);
   assign wr_svc      = (cfg_sel == SEL_SERVICE);
   assign new_en      = cfg_wdata[CTRL_EN_BIT];
   assign new_mode    = decode_mode(cfg_wdata[1:0]);
   assign restart     = wr_ctrl;
   assign restart_run = (new_mode != MODE_BMON);
   assign svc_allow   = en_q && (mode_q == MODE_WDG);
   assign pulse_clr   = !en_q || (wr_ctrl && !new_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_GPT;
         en_q     <= 1'b1;
         reload_q <= RST_RELOAD;
      end else begin
         if (wr_ctrl) begin
            mode_q <= new_mode;
            en_q   <= new_en;
         end
         if (wr_reload) begin
            reload_q <= cfg_wdata[CNT_W-1:0];
         end
      end
   end

   wdt_svc_unlock #(
      .DATA_W (DATA_W),
      .KEY_W  (KEY_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) svc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_is_svc (wr_svc),
      .wr_data   (cfg_wdata),
      .allow     (svc_allow),
      .kick_o    (kick)
   );

   wdt_down_counter #(
      .CNT_W   (CNT_W),
      .RST_VAL (RST_RELOAD)
   ) cnt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (en_q),
      .mode        (mode_q),
      .idle        (core_idle),
      .start_n     (bus_start_n),
      .ready_n     (bus_ready_n),
      .restart     (restart),
      .restart_run (restart_run),
      .kick        (kick),
      .reload_val  (reload_q),
      .cnt_o       (cnt),
      .expire_o    (expire)
   );

   wdt_pulse_stretch #(
      .PULSE_LEN (PULSE_LEN)
   ) pls_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (expire),
      .clear   (pulse_clr),
      .pulse_o (pulse)
   );

   assign tmo_pulse = pulse;
   assign tmo_irq_n = ~pulse;

endmodule

// File: rtl/wdt_sva.sv
module wdt_sva
   import wdt_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int PULSE_LEN = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmo,
   input logic             irq_n,
   input logic             en,
   input logic [1:0]       mode,
   input logic             idle,
   input logic             start_n,
   input logic             ready_n,
   input logic             restart,
   input logic             kick,
   input logic             expire,
   input logic             clr,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload
);

   localparam int LW = $clog2(PULSE_LEN + 1);
   localparam logic [LW-1:0] FULL = LW'(PULSE_LEN);
   localparam logic [LW-1:0] DEC  = LW'(1);

   logic [LW-1:0] left_q;

   // Independent tally of the clocks each pulse has left to run.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left_q <= '0;
      else if (clr)           left_q <= '0;
      else if (expire)        left_q <= FULL;
      else if (left_q != '0)  left_q <= left_q - DEC;
   end

   assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo == (left_q != '0));

   assert_irq_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo) |-> $fell(irq_n));

   assert_expire_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !clr) |=> tmo);

   assert_gpt_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_GPT && !restart && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

   assert_gpt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_GPT && !restart && cnt == '0) |=> cnt == $past(reload));

   assert_wdg_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_WDG && idle && !kick && !restart) |=> $stable(cnt));

   assert_kick_only_wdg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> (en && mode == MODE_WDG));

   assert_bmon_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_BMON && !start_n && !restart) |=> cnt == $past(reload));

   assert_bmon_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MODE_BMON && start_n && !ready_n && !restart) |=> $stable(cnt));

   assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> ($stable(cnt) && !tmo));

endmodule

bind wdog_busmon_timer wdt_sva #(
   .CNT_W     (CNT_W),
   .PULSE_LEN (PULSE_LEN)
) sva_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tmo     (tmo_pulse),
   .irq_n   (tmo_irq_n),
   .en      (en_q),
   .mode    (mode_q),
   .idle    (core_idle),
   .start_n (bus_start_n),
   .ready_n (bus_ready_n),
   .restart (restart),
   .kick    (kick),
   .expire  (expire),
   .clr     (pulse_clr),
   .cnt     (cnt),
   .reload  (reload_q)
);

// File: tb/wdog_busmon_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_busmon_timer_tb_top;

   localparam int RST_R = 24;
   localparam int PLEN  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_n = 1'b1;
   logic        ready_n = 1'b1;
   logic        idle = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic [31:0] wdata = '0;
   logic        tmo;
   logic        irq_n;

   int edge_cnt = 0;
   int checks = 0;
   int errors = 0;
   int last_edge = 0;
   int irq_bad = 0;

   always #5 clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;
   always @(negedge clk) if (irq_n !== ~tmo) irq_bad <= irq_bad + 1;

   wdog_busmon_timer #(
      .RST_RELOAD (32'(RST_R)),
      .PULSE_LEN  (PLEN)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_start_n (start_n),
      .bus_ready_n (ready_n),
      .core_idle   (idle),
      .cfg_we      (we),
      .cfg_sel     (sel),
      .cfg_wdata   (wdata),
      .tmo_pulse   (tmo),
      .tmo_irq_n   (irq_n)
   );

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge; last_edge = index of the edge that took the action.
   task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
      we = 1'b1; sel = s; wdata = d;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
      last_edge = edge_cnt;
   endtask

   task automatic bus_strobe(input bit do_start, input bit do_ready);
      start_n = !do_start; ready_n = !do_ready;
      @(posedge clk);
      @(negedge clk);
      start_n = 1'b1; ready_n = 1'b1;
      last_edge = edge_cnt;
   endtask

   task automatic wait_rise(input int limit, output int at);
      at = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (tmo) begin
            at = edge_cnt;
            break;
         end
      end
   endtask

   task automatic high_run(output int n);
      n = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (tmo) n++;
         else break;
      end
   endtask

   task automatic configure(input logic [1:0] mode, input int rel, output int c);
      reg_write(2'd0, 32'h0);
      reg_write(2'd1, 32'(rel));
      reg_write(2'd0, 32'h4 | {30'h0, mode});
      c = last_edge;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int rel, at, at2, n, c, s, lows;
      repeat (3) @(negedge clk);
      check_eq("R1", "tmo in reset", tmo, 0);
      check_eq("R1", "irq_n in reset", irq_n, 1);
      rst_n = 1'b1;
      rel = edge_cnt;
      wait_rise(RST_R + 10, at);
      check_eq("R1", "first rise after reset", at, rel + RST_R);
      high_run(n);
      check_eq("R3", "reset pulse width", n, PLEN);
      wait_rise(RST_R + 10, at2);
      check_eq("R2", "second period", at2, at + RST_R + 1);

      // R2/R3 sweep over reload values, idle toggled to show no effect
      for (int r = 8; r <= 40; r++) begin
         idle = r[0];
         configure(2'd0, r, c);
         wait_rise(r + 10, at);
         check_eq("R2", $sformatf("gpt rise reload %0d", r), at, c + r);
         high_run(n);
         check_eq("R3", $sformatf("width reload %0d", r), n, PLEN);
         wait_rise(r + 10, at2);
         check_eq("R2", $sformatf("gpt period reload %0d", r), at2, at + r + 1);
      end
      idle = 1'b0;

      // R11: reload write does not disturb running count; mode code 3 is GPT
      configure(2'd0, 20, c);
      repeat (4) @(negedge clk);
      reg_write(2'd1, 32'd30);
      wait_rise(40, at);
      check_eq("R11", "rise keeps old count", at, c + 20);
      high_run(n);
      wait_rise(50, at2);
      check_eq("R11", "new reload next period", at2, at + 31);
      configure(2'd3, 16, c);
      idle = 1'b1;
      wait_rise(40, at);
      idle = 1'b0;
      check_eq("R11", "mode code 3 as gpt", at, c + 16);

      // R6: watchdog idle hold
      configure(2'd1, 30, c);
      idle = 1'b1;
      repeat (12) @(negedge clk);
      idle = 1'b0;
      wait_rise(60, at);
      check_eq("R6", "idle extends timeout", at, c + 42);

      // R7: service sequences
      configure(2'd1, 30, c);
      repeat (10) @(negedge clk);
      reg_write(2'd2, 32'hAAAA);
      reg_write(2'd2, 32'h5555);
      s = last_edge;
      wait_rise(60, at);
      check_eq("R7", "valid service reloads", at, s + 30);
      configure(2'd1, 30, c);
      repeat (5) @(negedge clk);
      reg_write(2'd2, 32'hAAAA);
      reg_write(2'd1, 32'd30);
      reg_write(2'd2, 32'h5555);
      wait_rise(60, at);
      check_eq("R7", "broken sequence ignored", at, c + 30);
      configure(2'd1, 30, c);
      repeat (5) @(negedge clk);
      reg_write(2'd2, 32'hAAAA);
      reg_write(2'd2, 32'h5556);
      wait_rise(60, at);
      check_eq("R7", "wrong key ignored", at, c + 30);
      configure(2'd0, 30, c);
      repeat (5) @(negedge clk);
      reg_write(2'd2, 32'hAAAA);
      reg_write(2'd2, 32'h5555);
      wait_rise(60, at);
      check_eq("R7", "service ignored in gpt", at, c + 30);

      // R8/R9/R10: bus monitor
      configure(2'd2, 20, c);
      wait_rise(60, at);
      check_eq("R8", "stopped until start", at, -1);
      bus_strobe(1'b1, 1'b0);
      s = last_edge;
      wait_rise(40, at);
      check_eq("R8", "rise after start", at, s + 20);
      high_run(n);
      check_eq("R3", "bus monitor width", n, PLEN);
      wait_rise(60, at);
      check_eq("R8", "stays stopped after expiry", at, -1);
      bus_strobe(1'b1, 1'b0);
      repeat (5) @(negedge clk);
      bus_strobe(1'b0, 1'b1);
      wait_rise(60, at);
      check_eq("R9", "ready stops counter", at, -1);
      bus_strobe(1'b1, 1'b0);
      repeat (8) @(negedge clk);
      bus_strobe(1'b1, 1'b0);
      s = last_edge;
      wait_rise(40, at);
      check_eq("R8", "second start restarts", at, s + 20);
      high_run(n);
      bus_strobe(1'b1, 1'b1);
      s = last_edge;
      wait_rise(40, at);
      check_eq("R9", "start wins over ready", at, s + 20);
      high_run(n);
      idle = 1'b1;
      bus_strobe(1'b1, 1'b0);
      s = last_edge;
      wait_rise(40, at);
      idle = 1'b0;
      check_eq("R10", "idle ignored in bus monitor", at, s + 20);
      high_run(n);

      // R5: overlapping expiries keep the pulse high
      configure(2'd0, 3, c);
      wait_rise(10, at);
      check_eq("R5", "short reload rise", at, c + 3);
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!tmo) lows++;
      end
      check_eq("R5", "low samples during overlap", lows, 0);

      // R12: disable
      reg_write(2'd0, 32'h0);
      check_eq("R12", "tmo after disable", tmo, 0);
      wait_rise(100, at);
      check_eq("R12", "no pulse while disabled", at, -1);

      check_eq("R4", "irq_n inverse mismatches", irq_bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule